// File: doc/BRIEF.md
# Synchronous Burst SRAM with Bus-Turnaround Control

This block is a synthesizable model of a small pipelined synchronous SRAM. Its data bus is 36 bits wide, made of four 9-bit lanes, and each lane holds one data byte and the parity bit that belongs to it. An access starts on an enabled clock edge that registers the address. Further beats of a 4-beat burst are requested with an advance input. The burst walks the two low address bits in either linear or interleaved order, as chosen by a strap input. Reads are pipelined, so data appears two enabled clocks after the address. Writes take their data on the enabled clock that follows the address.

Most of the block decides when the data bus may be driven. The drive-enable output needs a valid read beat and a low asynchronous output enable. It is also forced off during the data phase of a write, on the cycle just after the device is selected again after being deselected, whenever the device is deselected, and while the sleep input is high. A low-active clock enable freezes all state, so the present cycle is stretched without deselecting the device. The bidirectional pins are modelled as an input bus, an output bus and a drive-enable flag, which the pad ring combines.

Top module: `burst_sram`

## Requirements
- R1: After a clock edge with `rst` high, the device is deselected and no read is pending, so `dq_oe` stays low until a new read completes.
- R2: Lane b of the bus uses bits [9b+8:9b], with bit 9b+8 as that byte's parity. A write updates lane b, parity included, only when `be_n[b]` was low with that beat's address. All other lanes keep their contents.
- R3: An address registered by a select-and-start edge (`start_n` low, `sel_n` low, `we_n` high) is read back on `dq_o`, with `dq_oe` high, right after the second enabled edge that follows. Each burst beat is driven for one enabled cycle.
- R4: A write start registers the address, the write flag and `be_n`. The data for that beat is sampled from `dq_i` at the next enabled edge. `dq_oe` is low between those two edges whatever `oe_n` is.
- R5: With `order_sel` low, each advance (`adv_n` low, `start_n` high) adds 1 modulo 4 to the two low address bits of the running burst, wrapping inside its aligned 4-word block.
- R6: With `order_sel` high, beat k of a burst uses the start address with its two low bits XORed with k. The upper address bits stay fixed.
- R7: `oe_n` acts without a clock: raising it drops `dq_oe` at once, and lowering it again restores the drive in the same cycle.
- R8: A start edge with `sel_n` high deselects the device. While deselected, `dq_oe` stays low, a read still in the pipeline is not driven, and advances are ignored.
- R9: On the cycle after a start edge that selects a deselected device, `dq_oe` is low.
- R10: While `cen_n` is high, clock edges change nothing: pending reads do not move, and `dq_o` and `dq_oe` hold their values. The device does not become deselected.
- R11: While `sleep` is high, `dq_oe` is low at once, starts and advances at enabled edges are ignored, and memory contents are kept. A start is accepted again at the first enabled edge after `sleep` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low |
| start_n | input | 1 | Start of access, active low; selects or deselects according to `sel_n` |
| adv_n | input | 1 | Burst advance, active low, used when `start_n` is high |
| sel_n | input | 1 | Chip select sampled on a start, active low |
| we_n | input | 1 | Write when low, read when high; sampled on a start |
| be_n | input | 4 | Per-lane write enables, active low, sampled with each beat's address |
| addr | input | 4 | Word address |
| order_sel | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| dq_i | input | 36 | Data and parity arriving from the pins |
| dq_o | output | 36 | Registered read data toward the pins |
| dq_oe | output | 1 | Pin drive enable for `dq_o` |

## Verification
The bench runs a write burst and a read burst that wraps past the end of its aligned block. A wrong wrap would return the words in the wrong order. A masked write changes only two lanes, so a design that tied parity to the wrong enable, or wrote every lane, returns a mixed word that differs from the expected one. Separate tests cover the forced-off cases: a read followed by a deselect, the first cycle after reselect, sleep during a valid read, and a read followed at once by a write. A leaky drive gate would show `dq_oe` high in one of these. Clock-enable stalls are placed both before the read data appears and while it is being driven, which exposes a pipeline that moves, or data that changes, on a masked edge.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;

  // Defaults shared by the design and its users
  localparam int SBS_DEPTH_DEF  = 16;
  localparam int SBS_LANES_DEF  = 4;
  localparam int SBS_LANE_W_DEF = 9;
  // Burst of 4 beats walks two low address bits
  localparam int SBS_BEAT_W     = 2;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

  // Low address bits for a given beat of a burst
  function automatic logic [SBS_BEAT_W-1:0] beat_low(
    input logic [SBS_BEAT_W-1:0] base,
    input logic [SBS_BEAT_W-1:0] beat,
    input burst_order_e          ord
  );
    return (ord == ORDER_INTERLEAVED) ? (base ^ beat) : (base + beat);
  endfunction

endpackage

// File: rtl/sbs_burst_gen.sv
`timescale 1ns/1ps
module sbs_burst_gen
  import sbs_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                live,
  input  logic                load,
  input  logic                step,
  input  burst_order_e        ord,
  input  logic [AW-1:0]       start_addr,
  output logic [AW-1:0]       cur_addr
);

  localparam int BW = SBS_BEAT_W;
  localparam logic [BW-1:0] BEAT_ONE = {{(BW-1){1'b0}}, 1'b1};

  logic [AW-1:0] base_q;
  logic [BW-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (live) begin
      if (load) begin
        base_q <= start_addr;
        beat_q <= '0;
      end else if (step) begin
        beat_q <= beat_q + BEAT_ONE;
      end
    end
  end

  assign cur_addr = {base_q[AW-1:BW], beat_low(base_q[BW-1:0], beat_q, ord)};

  // A new start points the access at the given address
  p_load_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (live && load) |=> (cur_addr == $past(start_addr)));

  // Linear order moves one word ahead, wrapping in the block
  p_linear_step_r5: assert property (@(posedge clk) disable iff (rst)
    (live && step && !load && ord == ORDER_LINEAR) |=>
    (ord != ORDER_LINEAR || cur_addr[BW-1:0] == $past(cur_addr[BW-1:0]) + BEAT_ONE));

  // Any beat stays inside the aligned block of its start
  p_block_fixed_r6: assert property (@(posedge clk) disable iff (rst)
    (live && step && !load) |=> (cur_addr[AW-1:BW] == $past(cur_addr[AW-1:BW])));

endmodule

// File: rtl/sbs_lane_ram.sv
`timescale 1ns/1ps
module sbs_lane_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int W     = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // Single-port array with registered read, shaped for block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/sbs_bus_ctrl.sv
`timescale 1ns/1ps
module sbs_bus_ctrl #(
  parameter int BUS_W = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             sleep,
  input  logic             rd_fire,
  input  logic             selected,
  input  logic             wake,
  input  logic             wr_phase,
  input  logic             oe_n,
  input  logic [BUS_W-1:0] ram_q,
  output logic [BUS_W-1:0] dq_o,
  output logic             dq_oe
);

  logic             rd_v1_q;
  logic             rd_v2_q;
  logic [BUS_W-1:0] dq_q;

  // Second pipeline stage: array word into the output register
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v1_q <= 1'b0;
      rd_v2_q <= 1'b0;
      dq_q    <= '0;
    end else if (en) begin
      if (sleep) begin
        rd_v1_q <= 1'b0;
        rd_v2_q <= 1'b0;
      end else begin
        rd_v1_q <= rd_fire;
        rd_v2_q <= rd_v1_q;
        if (rd_v1_q) dq_q <= ram_q;
      end
    end
  end

  assign dq_o  = dq_q;
  // Registered qualifiers combined with the two asynchronous inputs
  assign dq_oe = rd_v2_q & selected & ~wake & ~wr_phase & ~oe_n & ~sleep;

  // A masked clock edge leaves the output word untouched
  p_hold_out_r10: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> $stable(dq_o));

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
  import sbs_pkg::*;
#(
  parameter int DEPTH  = SBS_DEPTH_DEF,
  parameter int LANES  = SBS_LANES_DEF,
  parameter int LANE_W = SBS_LANE_W_DEF,
  localparam int AW    = $clog2(DEPTH),
  localparam int BUS_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cen_n,
  input  logic             start_n,
  input  logic             adv_n,
  input  logic             sel_n,
  input  logic             we_n,
  input  logic [LANES-1:0] be_n,
  input  logic [AW-1:0]    addr,
  input  logic             order_sel,
  input  logic             oe_n,
  input  logic             sleep,
  input  logic [BUS_W-1:0] dq_i,
  output logic [BUS_W-1:0] dq_o,
  output logic             dq_oe
);

  logic en;
  logic live;
  logic start_acc;
  logic desel;
  logic step;

  logic selected_q;
  logic wake_q;
  logic burst_on_q;
  logic burst_wr_q;
  logic slot_v_q;
  logic slot_wr_q;
  logic [LANES-1:0] slot_be_q;

  logic [AW-1:0]    cur_addr;
  logic [BUS_W-1:0] ram_q;
  burst_order_e     ord;

  assign en        = ~cen_n;
  assign live      = en & ~sleep;
  assign start_acc = ~start_n & ~sel_n;
  assign desel     = ~start_n & sel_n;
  assign step      = start_n & ~adv_n & burst_on_q;
  assign ord       = burst_order_e'(order_sel);

  // Access slot: one beat whose address is held by the burst generator
  always_ff @(posedge clk) begin
    if (rst) begin
      selected_q <= 1'b0;
      wake_q     <= 1'b0;
      burst_on_q <= 1'b0;
      burst_wr_q <= 1'b0;
      slot_v_q   <= 1'b0;
      slot_wr_q  <= 1'b0;
      slot_be_q  <= '0;
    end else if (en) begin
      if (sleep) begin
        slot_v_q <= 1'b0;
        wake_q   <= 1'b0;
      end else begin
        wake_q    <= start_acc & ~selected_q;
        slot_v_q  <= start_acc | step;
        slot_be_q <= ~be_n;
        if (start_acc) begin
          selected_q <= 1'b1;
          burst_on_q <= 1'b1;
          burst_wr_q <= ~we_n;
          slot_wr_q  <= ~we_n;
        end else begin
          slot_wr_q <= burst_wr_q;
          if (desel) begin
            selected_q <= 1'b0;
            burst_on_q <= 1'b0;
          end
        end
      end
    end
  end

  sbs_burst_gen #(
    .AW(AW)
  ) u_burst (
    .clk        (clk),
    .rst        (rst),
    .live       (live),
    .load       (start_acc),
    .step       (step),
    .ord        (ord),
    .start_addr (addr),
    .cur_addr   (cur_addr)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sbs_lane_ram #(
      .DEPTH (DEPTH),
      .AW    (AW),
      .W     (LANE_W)
    ) u_ram (
      .clk   (clk),
      .we    (live & slot_v_q & slot_wr_q & slot_be_q[l]),
      .re    (live & slot_v_q & ~slot_wr_q),
      .addr  (cur_addr),
      .wdata (dq_i[l*LANE_W +: LANE_W]),
      .rdata (ram_q[l*LANE_W +: LANE_W])
    );
  end

  sbs_bus_ctrl #(
    .BUS_W(BUS_W)
  ) u_bus (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .sleep    (sleep),
    .rd_fire  (slot_v_q & ~slot_wr_q),
    .selected (selected_q),
    .wake     (wake_q),
    .wr_phase (slot_v_q & slot_wr_q),
    .oe_n     (oe_n),
    .ram_q    (ram_q),
    .dq_o     (dq_o),
    .dq_oe    (dq_oe)
  );

  // Write data phase keeps the pins floating
  p_wr_phase_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (live && start_acc && !we_n) |=> !dq_oe);

  // Deselecting floats the pins on the following cycle
  p_desel_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (live && desel) |=> !dq_oe);

  // First cycle after reselect is a turnaround cycle
  p_turnaround_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (live && start_acc && !selected_q) |=> !dq_oe);

  // An enabled edge in sleep flushes any pending read
  p_sleep_flush_r11: assert property (@(posedge clk) disable iff (rst)
    (en && sleep) |=> !dq_oe);

endmodule

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;

  localparam logic [35:0] W0 = 36'h123456789;
  localparam logic [35:0] W1 = 36'h9ABCDEF01;
  localparam logic [35:0] W2 = 36'hFEDCBA987;
  localparam logic [35:0] W3 = 36'h0F0F0F0F0;
  localparam logic [35:0] NV = 36'hFFFFFFFFF;
  localparam logic [35:0] QV = 36'h5A5A5A5A5;

  // Expected word after a lane-masked write (R2 layout: 9-bit lanes)
  function automatic logic [35:0] lane_mix(input logic [35:0] old_w,
                                           input logic [35:0] new_w,
                                           input logic [3:0]  ben);
    logic [35:0] r;
    r = old_w;
    for (int l = 0; l < 4; l++)
      if (!ben[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
    return r;
  endfunction

  localparam logic [35:0] MIX = lane_mix(W0, NV, 4'b0101);

  typedef struct packed {
    logic        start_n;
    logic        adv_n;
    logic        sel_n;
    logic        we_n;
    logic [3:0]  be_n;
    logic [3:0]  addr;
    logic [35:0] din;
    logic        exp_oe;
    logic [35:0] exp_dq;
  } vec_t;

  localparam int NV_ROWS = 18;
  localparam vec_t [0:NV_ROWS-1] VEC = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'h0,    4'd4, 36'h0, 1'b0, 36'h0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'h0,    4'd0, W0,    1'b0, 36'h0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'h0,    4'd0, W1,    1'b0, 36'h0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'h0,    4'd0, W2,    1'b0, 36'h0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'hF,    4'd0, W3,    1'b0, 36'h0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 4'hF,    4'd6, 36'h0, 1'b0, 36'h0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'hF,    4'd0, 36'h0, 1'b0, 36'h0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'hF,    4'd0, 36'h0, 1'b1, W2},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'hF,    4'd0, 36'h0, 1'b1, W3},
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'hF,    4'd0, 36'h0, 1'b1, W0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'hF,    4'd0, 36'h0, 1'b1, W1},
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'hF,    4'd0, 36'h0, 1'b0, 36'h0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'b0101, 4'd4, 36'h0, 1'b0, 36'h0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'hF,    4'd0, NV,    1'b0, 36'h0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 4'hF,    4'd4, 36'h0, 1'b0, 36'h0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'hF,    4'd0, 36'h0, 1'b0, 36'h0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'hF,    4'd0, 36'h0, 1'b1, MIX},
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'hF,    4'd0, 36'h0, 1'b0, 36'h0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cen_n = 1'b0;
  logic        start_n = 1'b1;
  logic        adv_n = 1'b1;
  logic        sel_n = 1'b1;
  logic        we_n = 1'b1;
  logic [3:0]  be_n = 4'hF;
  logic [3:0]  addr = 4'd0;
  logic        order_sel = 1'b0;
  logic        oe_n = 1'b0;
  logic        sleep = 1'b0;
  logic [35:0] dq_i = 36'h0;
  logic [35:0] dq_o;
  logic        dq_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  burst_sram uut (
    .clk(clk), .rst(rst), .cen_n(cen_n), .start_n(start_n), .adv_n(adv_n),
    .sel_n(sel_n), .we_n(we_n), .be_n(be_n), .addr(addr),
    .order_sel(order_sel), .oe_n(oe_n), .sleep(sleep),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_bus(input string tag, input logic exp_oe, input logic [35:0] exp_dq);
    check({tag, " drive"}, {35'h0, dq_oe}, {35'h0, exp_oe});
    if (exp_oe) check({tag, " data"}, dq_o, exp_dq);
  endtask

  task automatic tick(input logic c, input logic st, input logic ad, input logic se,
                      input logic we, input logic [3:0] be, input logic [3:0] a,
                      input logic [35:0] d);
    @(negedge clk);
    cen_n = c; start_n = st; adv_n = ad; sel_n = se; we_n = we;
    be_n = be; addr = a; dq_i = d;
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [3:0] a);
    tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, a, 36'h0);
  endtask
  task automatic wr(input logic [3:0] a, input logic [3:0] be);
    tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, be, a, 36'h0);
  endtask
  task automatic idle(input logic [35:0] d);
    tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 4'd0, d);
  endtask
  task automatic adv();
    tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 4'd0, 36'h0);
  endtask
  task automatic hold();
    tick(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 4'd0, 36'h0);
  endtask
  task automatic desel();
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 4'd0, 36'h0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    expect_bus("R1 after reset", 1'b0, 36'h0);

    // Table: write burst, linear read burst with wrap, masked write
    for (int i = 0; i < NV_ROWS; i++) begin
      tick(1'b0, VEC[i].start_n, VEC[i].adv_n, VEC[i].sel_n, VEC[i].we_n,
           VEC[i].be_n, VEC[i].addr, VEC[i].din);
      expect_bus($sformatf("R2 R3 R4 R5 table row %0d", i), VEC[i].exp_oe, VEC[i].exp_dq);
    end

    // R6: interleaved burst from address 5 visits 5,4,7,6
    order_sel = 1'b1;
    rd(4'd5);
    adv();
    adv();
    expect_bus("R6 beat0", 1'b1, W1);
    adv();
    expect_bus("R6 beat1", 1'b1, MIX);
    idle(36'h0);
    expect_bus("R6 beat2", 1'b1, W3);
    idle(36'h0);
    expect_bus("R6 beat3", 1'b1, W2);
    idle(36'h0);
    expect_bus("R6 end", 1'b0, 36'h0);
    order_sel = 1'b0;

    // R7: output enable acts between edges
    rd(4'd6);
    idle(36'h0);
    idle(36'h0);
    expect_bus("R7 driving", 1'b1, W2);
    oe_n = 1'b1;
    #1;
    expect_bus("R7 oe high", 1'b0, 36'h0);
    oe_n = 1'b0;
    #1;
    expect_bus("R7 oe low again", 1'b1, W2);
    idle(36'h0);

    // R10: clock enable stalls before and during the data beat
    rd(4'd7);
    idle(36'h0);
    hold();
    expect_bus("R10 hold 1", 1'b0, 36'h0);
    hold();
    expect_bus("R10 hold 2", 1'b0, 36'h0);
    hold();
    expect_bus("R10 hold 3", 1'b0, 36'h0);
    idle(36'h0);
    expect_bus("R10 resumed", 1'b1, W3);
    hold();
    expect_bus("R10 held beat", 1'b1, W3);
    idle(36'h0);
    expect_bus("R10 beat done", 1'b0, 36'h0);

    // R4: read followed at once by a write
    rd(4'd5);
    wr(4'd6, 4'h0);
    expect_bus("R4 write phase", 1'b0, 36'h0);
    idle(QV);
    expect_bus("R4 prior read", 1'b1, W1);
    idle(36'h0);
    rd(4'd6);
    idle(36'h0);
    idle(36'h0);
    expect_bus("R4 written word", 1'b1, QV);
    idle(36'h0);

    // R8: deselect hides pending read and ignores advances
    rd(4'd7);
    desel();
    expect_bus("R8 deselect edge", 1'b0, 36'h0);
    idle(36'h0);
    expect_bus("R8 pending read hidden", 1'b0, 36'h0);
    adv();
    expect_bus("R8 adv ignored 1", 1'b0, 36'h0);
    adv();
    expect_bus("R8 adv ignored 2", 1'b0, 36'h0);

    // R9: reselect, first cycle floats, data then appears
    rd(4'd7);
    expect_bus("R9 turnaround", 1'b0, 36'h0);
    idle(36'h0);
    idle(36'h0);
    expect_bus("R9 R3 after reselect", 1'b1, W3);
    idle(36'h0);

    // R11: sleep floats pins, ignores a write, keeps contents
    rd(4'd5);
    idle(36'h0);
    idle(36'h0);
    expect_bus("R11 before sleep", 1'b1, W1);
    sleep = 1'b1;
    #1;
    expect_bus("R11 sleep floats", 1'b0, 36'h0);
    wr(4'd5, 4'h0);
    expect_bus("R11 sleep write edge", 1'b0, 36'h0);
    idle(36'h0);
    expect_bus("R11 sleep data edge", 1'b0, 36'h0);
    sleep = 1'b0;
    rd(4'd5);
    idle(36'h0);
    idle(36'h0);
    expect_bus("R11 contents kept", 1'b1, W1);
    idle(36'h0);

    // R1: reset clears a read already in the pipeline
    rd(4'd4);
    idle(36'h0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    expect_bus("R1 during reset", 1'b0, 36'h0);
    @(negedge clk);
    rst = 1'b0;
    idle(36'h0);
    expect_bus("R1 pipeline cleared", 1'b0, 36'h0);
    adv();
    expect_bus("R1 deselected after reset", 1'b0, 36'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule